// File: doc/BRIEF.md
# Cascaded Masked Interrupt Controller

This block gathers ninety-six interrupt sources into one CPU interrupt line and a number the CPU can read back. Two groups of thirty-two level inputs from on-chip units are captured every cycle into a low and a high main cause register. A third group of thirty-two general-purpose port pins is edge-captured into a port cause register. That register does not reach the CPU directly: its enabled, pending bits are folded into a summary field at bits 24..27 of the high main cause view.

Each group has a mask register in which a 1 enables the matching cause bit. A fixed valid-bit filter on each main group decides which cause bits may take part at all. A word-addressed register port gives software the masks, the three cause registers and a vector register. The vector register holds the number of the winning source, or a spurious code when nothing enabled is pending. Software clears port causes by writing a word that has zeros in the bits to clear.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After a synchronous active-low reset the three mask registers and the port cause register are 0, `irq_out` is 0 and the vector register reads the spurious code 0xFFFF_FFFE.
- R2: Source numbers are assigned as follows: 0..31 are low main cause bits 0..31, 32..63 are high main cause bits 0..31 and 64..95 are port cause bits 0..31. The vector register always returns either a number below 96 or the spurious code.
- R3: Resolution takes the low main group first. The high main group is searched only when no enabled, valid low bit is pending.
- R4: Only low cause bits set in 0x3DFF_FFFE and high cause bits set in 0x0F00_0DB7 can win or raise `irq_out`. Other bits are still visible when the cause registers are read.
- R5: Within a group the lowest-numbered enabled pending bit wins.
- R6: A mask bit of 0 stops its source from winning and from raising `irq_out`, but leaves its cause bit set. This holds for the summary field as well: a high mask of 0 at bits 24..27 blocks every port source.
- R7: A port cause bit is set by a rising edge of its pin. A pin that stays high does not set the bit again after it has been cleared.
- R8: A write to the port cause register clears every bit written as 0 and leaves every bit written as 1 unchanged. When a rising edge and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: High cause bits 24..27 all read as the OR of (port cause AND port mask). When the high winner index is 24 or above, the vector is 64 plus the lowest enabled pending port bit index.
- R10: `irq_out` is 1 exactly when the vector register holds a number other than the spurious code.
- R11: Main cause bits take the value of their source inputs one clock later. Writes to the low or high cause address change nothing.
- R12: The register addresses are 0 low mask, 1 high mask, 2 port mask, 3 low cause, 4 high cause, 5 port cause and 6 vector. Masks read back what was written, address 7 reads 0 and ignores writes, and reading the vector has no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lo_src | input | 32 | Level sources for numbers 0..31 |
| hi_src | input | 32 | Level sources for numbers 32..63 (bits 24..27 are replaced by the summary) |
| port_in | input | 32 | Port pins for numbers 64..95, edge captured |
| bus_addr | input | 3 | Word address of the register access |
| bus_wr | input | 1 | Write strobe for `bus_wdata` at `bus_addr` |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | CPU interrupt request |

## Verification
The bound checker watches several behaviours on every cycle. It checks that the CPU line agrees with the vector register, that the vector never leaves the legal number range, and that the summary field tracks the masked port causes. It also checks that main causes follow their sources one cycle late, that every port edge lands in the cause register, and that no port bit is set without an edge. Other behaviours need a scenario and are shown only by the directed bench. These are the exact winner under competing sources across the groups, the effect of the valid filters and of each mask, and the partial write-zero clears. The bench also covers the set-beats-clear collision and the register map, including the unmapped address.

// File: rtl/irq_cascade_pkg.sv
// Package: shared constants for the cascaded interrupt controller.
// Assumes 32-bit groups; register addresses are word indices.
package irq_cascade_pkg;

    // Fixed valid-bit filters of the two main groups
    localparam logic [31:0] PKG_LO_VALID = 32'h3DFF_FFFE;
    localparam logic [31:0] PKG_HI_VALID = 32'h0F00_0DB7;

    // Placement of the cascade summary inside the high main group
    localparam int unsigned PKG_SUM_LSB = 24;
    localparam int unsigned PKG_SUM_N   = 4;

    // Register word addresses
    localparam logic [2:0] ADR_LO_MASK    = 3'd0;
    localparam logic [2:0] ADR_HI_MASK    = 3'd1;
    localparam logic [2:0] ADR_PORT_MASK  = 3'd2;
    localparam logic [2:0] ADR_LO_CAUSE   = 3'd3;
    localparam logic [2:0] ADR_HI_CAUSE   = 3'd4;
    localparam logic [2:0] ADR_PORT_CAUSE = 3'd5;
    localparam logic [2:0] ADR_VECTOR     = 3'd6;

endpackage

// File: rtl/irq_lowest_set.sv
// Module: irq_lowest_set
// Finds the lowest set bit of a vector. 'found' is 0 and 'idx' is 0 when the
// vector is empty. Purely combinational.
module irq_lowest_set #(
    parameter  int unsigned W  = 32,
    localparam int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Scan from the top so the last hit taken is the lowest index
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_main_group.sv
// Module: irq_main_group
// One main cause group. It registers level sources each cycle and overlays an
// optional summary field. It then applies the fixed valid filter and the mask.
// Assumes SUM_FIELD is 0 for a group without a cascade.
module irq_main_group #(
    parameter int unsigned     W         = 32,
    parameter logic [W-1:0]    VALID     = '1,
    parameter logic [W-1:0]    SUM_FIELD = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  src,
    input  logic          summary,
    input  logic [W-1:0]  mask,
    output logic [W-1:0]  cause_view,
    output logic [W-1:0]  pend
);

    logic [W-1:0] lat_q;

    // Capture source levels; the summary positions are owned by the cascade
    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= src & ~SUM_FIELD;
    end

    // Software-visible cause with the summary field merged in
    assign cause_view = (lat_q & ~SUM_FIELD) | (summary ? SUM_FIELD : '0);

    // Bits allowed to compete: valid and enabled
    assign pend = cause_view & VALID & mask;

endmodule

// File: rtl/irq_port_group.sv
// Module: irq_port_group
// Port cause group. A rising pin edge sets a sticky cause bit. A clear word
// writes zeros to clear and ones to keep. An edge wins over a clear in the
// same cycle. Assumes the pins are already synchronous to clk.
module irq_port_group #(
    parameter int unsigned W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  pin,
    input  logic          clr_we,
    input  logic [W-1:0]  clr_word,
    input  logic [W-1:0]  mask,
    output logic [W-1:0]  cause,
    output logic [W-1:0]  rise,
    output logic [W-1:0]  pend
);

    logic [W-1:0] pin_q;
    logic [W-1:0] cause_q;
    logic [W-1:0] keep;

    // Remember the pin levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin;
    end

    assign rise = pin & ~pin_q;
    assign keep = clr_we ? clr_word : '1;

    // Sticky causes: clear first, then OR in new edges so the set wins
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & keep) | rise;
    end

    assign cause = cause_q;
    assign pend  = cause_q & mask;

endmodule

// File: rtl/irq_vector_resolve.sv
// Module: irq_vector_resolve
// Turns the three masked pending vectors into one interrupt number. Low group
// first, then high. A high winner inside the summary field is redirected to
// the port group. Anything unresolved gives SPUR. Purely combinational.
module irq_vector_resolve #(
    parameter  int unsigned         W       = 32,
    parameter  int unsigned         DATA_W  = 32,
    parameter  int unsigned         SUM_LSB = 24,
    parameter  logic [DATA_W-1:0]   SPUR    = '1,
    localparam int unsigned         IW      = $clog2(W)
) (
    input  logic [W-1:0]       lo_pend,
    input  logic [W-1:0]       hi_pend,
    input  logic [W-1:0]       port_pend,
    output logic [DATA_W-1:0]  vec
);

    logic [2:0][W-1:0]  grp;
    logic [2:0]         hit;
    logic [2:0][IW-1:0] pos;

    assign grp[0] = lo_pend;
    assign grp[1] = hi_pend;
    assign grp[2] = port_pend;

    // One lowest-bit finder per group
    for (genvar g = 0; g < 3; g++) begin : g_enc
        irq_lowest_set #(.W(W)) u_enc (
            .vec   (grp[g]),
            .found (hit[g]),
            .idx   (pos[g])
        );
    end

    // Fixed order: low, then high, with the cascade step into the port group
    always_comb begin
        if (hit[0]) begin
            vec = DATA_W'(pos[0]);
        end else if (hit[1]) begin
            if (pos[1] >= IW'(SUM_LSB)) begin
                if (hit[2]) vec = DATA_W'(2 * W) + DATA_W'(pos[2]);
                else        vec = SPUR;
            end else begin
                vec = DATA_W'(W) + DATA_W'(pos[1]);
            end
        end else begin
            vec = SPUR;
        end
    end

endmodule

// File: rtl/irq_cascade_ctrl.sv
// Module: irq_cascade_ctrl (top)
// Cascaded masked interrupt controller: two level-captured main groups, one
// edge-captured port group whose masked OR drives the summary field of the
// high group, three mask registers, a word-addressed register port and a
// combinational vector register. Assumes a synchronous single-clock bus.
module irq_cascade_ctrl
    import irq_cascade_pkg::*;
#(
    parameter int unsigned       GRP_W    = 32,
    parameter int unsigned       DATA_W   = 32,
    parameter int unsigned       ADDR_W   = 3,
    parameter int unsigned       SUM_LSB  = PKG_SUM_LSB,
    parameter int unsigned       SUM_N    = PKG_SUM_N,
    parameter logic [GRP_W-1:0]  LO_VALID = PKG_LO_VALID,
    parameter logic [GRP_W-1:0]  HI_VALID = PKG_HI_VALID
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [GRP_W-1:0]   lo_src,
    input  logic [GRP_W-1:0]   hi_src,
    input  logic [GRP_W-1:0]   port_in,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_out
);

    localparam logic [GRP_W-1:0]  SUM_FIELD = GRP_W'({SUM_N{1'b1}}) << SUM_LSB;
    localparam logic [DATA_W-1:0] SPUR      = ~DATA_W'(1);

    logic [GRP_W-1:0]  lo_mask_q, hi_mask_q, port_mask_q;
    logic [GRP_W-1:0]  lo_cause, hi_cause, port_cause;
    logic [GRP_W-1:0]  lo_pend, hi_pend, port_pend, port_rise;
    logic              summary;
    logic              port_clr_we;
    logic [DATA_W-1:0] vec_num;

    // Mask registers: write-through, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_mask_q   <= '0;
            hi_mask_q   <= '0;
            port_mask_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(ADR_LO_MASK))   lo_mask_q   <= GRP_W'(bus_wdata);
            if (bus_addr == ADDR_W'(ADR_HI_MASK))   hi_mask_q   <= GRP_W'(bus_wdata);
            if (bus_addr == ADDR_W'(ADR_PORT_MASK)) port_mask_q <= GRP_W'(bus_wdata);
        end
    end

    assign port_clr_we = bus_wr && (bus_addr == ADDR_W'(ADR_PORT_CAUSE));

    irq_port_group #(.W(GRP_W)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (port_in),
        .clr_we   (port_clr_we),
        .clr_word (GRP_W'(bus_wdata)),
        .mask     (port_mask_q),
        .cause    (port_cause),
        .rise     (port_rise),
        .pend     (port_pend)
    );

    // Cascade: any enabled pending port bit lights the summary field
    assign summary = |port_pend;

    irq_main_group #(.W(GRP_W), .VALID(LO_VALID), .SUM_FIELD('0)) u_lo (
        .clk        (clk),
        .rst_n      (rst_n),
        .src        (lo_src),
        .summary    (1'b0),
        .mask       (lo_mask_q),
        .cause_view (lo_cause),
        .pend       (lo_pend)
    );

    irq_main_group #(.W(GRP_W), .VALID(HI_VALID), .SUM_FIELD(SUM_FIELD)) u_hi (
        .clk        (clk),
        .rst_n      (rst_n),
        .src        (hi_src),
        .summary    (summary),
        .mask       (hi_mask_q),
        .cause_view (hi_cause),
        .pend       (hi_pend)
    );

    irq_vector_resolve #(
        .W(GRP_W), .DATA_W(DATA_W), .SUM_LSB(SUM_LSB), .SPUR(SPUR)
    ) u_res (
        .lo_pend   (lo_pend),
        .hi_pend   (hi_pend),
        .port_pend (port_pend),
        .vec       (vec_num)
    );

    // CPU line: any enabled, valid main bit (summary included)
    assign irq_out = (|lo_pend) | (|hi_pend);

    // Read mux: pure reads, unmapped addresses return zero
    always_comb begin
        case (bus_addr)
            ADDR_W'(ADR_LO_MASK):    bus_rdata = DATA_W'(lo_mask_q);
            ADDR_W'(ADR_HI_MASK):    bus_rdata = DATA_W'(hi_mask_q);
            ADDR_W'(ADR_PORT_MASK):  bus_rdata = DATA_W'(port_mask_q);
            ADDR_W'(ADR_LO_CAUSE):   bus_rdata = DATA_W'(lo_cause);
            ADDR_W'(ADR_HI_CAUSE):   bus_rdata = DATA_W'(hi_cause);
            ADDR_W'(ADR_PORT_CAUSE): bus_rdata = DATA_W'(port_cause);
            ADDR_W'(ADR_VECTOR):     bus_rdata = vec_num;
            default:                 bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_cascade_chk.sv
// Module: irq_cascade_chk
// Assertion checker bound into irq_cascade_ctrl. It observes only and drives
// nothing.
module irq_cascade_chk #(
    parameter int unsigned GRP_W   = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned SUM_LSB = 24,
    parameter int unsigned SUM_N   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [GRP_W-1:0]   lo_src,
    input logic [GRP_W-1:0]   lo_cause,
    input logic [GRP_W-1:0]   hi_cause,
    input logic [GRP_W-1:0]   port_cause,
    input logic [GRP_W-1:0]   port_rise,
    input logic [GRP_W-1:0]   lo_mask_q,
    input logic [GRP_W-1:0]   hi_mask_q,
    input logic [GRP_W-1:0]   port_mask_q,
    input logic [DATA_W-1:0]  vec_num,
    input logic               irq_out
);

    localparam logic [DATA_W-1:0] SPUR = ~DATA_W'(1);

    // R1
    reset_clears_state_chk: assert property (@(posedge clk)
        !rst_n |=> (lo_mask_q == '0 && hi_mask_q == '0 &&
                    port_mask_q == '0 && port_cause == '0));

    // R10
    irq_means_number_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> vec_num != SPUR);

    // R10
    idle_means_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out |-> vec_num == SPUR);

    // R2
    vector_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_num == SPUR) || (vec_num < DATA_W'(3 * GRP_W)));

    // R9
    summary_tracks_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cause[SUM_LSB +: SUM_N] == {SUM_N{|(port_cause & port_mask_q)}});

    // R11
    main_follows_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> lo_cause == $past(lo_src));

    // R8
    edge_sets_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rise != '0) |=> ((port_cause & $past(port_rise)) == $past(port_rise)));

    // R7
    no_set_without_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((port_cause & ~$past(port_cause) & ~$past(port_rise)) == '0));

endmodule

bind irq_cascade_ctrl irq_cascade_chk #(
    .GRP_W(GRP_W), .DATA_W(DATA_W), .SUM_LSB(SUM_LSB), .SUM_N(SUM_N)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lo_src      (lo_src),
    .lo_cause    (lo_cause),
    .hi_cause    (hi_cause),
    .port_cause  (port_cause),
    .port_rise   (port_rise),
    .lo_mask_q   (lo_mask_q),
    .hi_mask_q   (hi_mask_q),
    .port_mask_q (port_mask_q),
    .vec_num     (vec_num),
    .irq_out     (irq_out)
);

// File: tb/irq_cascade_ctrl_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module irq_cascade_ctrl_tb;

    localparam logic [2:0]  A_LOM = 3'd0, A_HIM = 3'd1, A_PTM = 3'd2;
    localparam logic [2:0]  A_LOC = 3'd3, A_HIC = 3'd4, A_PTC = 3'd5;
    localparam logic [2:0]  A_VEC = 3'd6, A_NONE = 3'd7;
    localparam logic [31:0] SPUR  = 32'hFFFF_FFFE;
    localparam int          WD_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] lo_src, hi_src, port_in;
    logic [2:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    irq_cascade_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .lo_src    (lo_src),
        .hi_src    (hi_src),
        .port_in   (port_in),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_LIMIT && !done) begin
            errors++;
            $display("FAIL watchdog: cycles %0d expected below %0d", cyc, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_reg(input string req, input string what,
                             input logic [2:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, what, bus_rdata, exp);
    endtask

    task automatic check_irq(input string req, input logic exp);
        #1;
        check(req, "irq_out", {31'b0, irq_out}, {31'b0, exp});
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic drive(input logic [31:0] lo, input logic [31:0] hi,
                         input logic [31:0] pt);
        @(negedge clk);
        lo_src = lo; hi_src = hi; port_in = pt;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check_reg("R1", "low mask", A_LOM, 32'h0);
        check_reg("R1", "high mask", A_HIM, 32'h0);
        check_reg("R1", "port mask", A_PTM, 32'h0);
        check_reg("R1", "port cause", A_PTC, 32'h0);
        check_reg("R1", "vector", A_VEC, SPUR);
        check_irq("R1", 1'b0);
    endtask

    task automatic t_low_group;
        wr(A_LOM, 32'hFFFF_FFFF);
        check_reg("R12", "low mask readback", A_LOM, 32'hFFFF_FFFF);
        drive(32'h0000_0020, 32'h0, 32'h0);
        check_reg("R2", "low bit 5 number", A_VEC, 32'd5);
        check_irq("R10", 1'b1);
        drive(32'h0000_0220, 32'h0, 32'h0);
        check_reg("R5", "lowest of bits 5 and 9", A_VEC, 32'd5);
        drive(32'h0000_0200, 32'h0, 32'h0);
        check_reg("R11", "low cause follows source", A_LOC, 32'h0000_0200);
        check_reg("R2", "low bit 9 number", A_VEC, 32'd9);
    endtask

    task automatic t_filter_and_mask;
        drive(32'h0200_0001, 32'h0, 32'h0);
        check_reg("R4", "invalid low bits 0,25", A_VEC, SPUR);
        check_irq("R4", 1'b0);
        check_reg("R4", "invalid bits still visible", A_LOC, 32'h0200_0001);
        drive(32'h0000_0020, 32'h0, 32'h0);
        wr(A_LOM, ~32'h0000_0020);
        check_reg("R6", "masked low bit", A_VEC, SPUR);
        check_irq("R6", 1'b0);
        check_reg("R6", "masked cause kept", A_LOC, 32'h0000_0020);
        wr(A_LOM, 32'hFFFF_FFFF);
        check_reg("R6", "unmasked low bit", A_VEC, 32'd5);
    endtask

    task automatic t_high_group;
        wr(A_HIM, 32'hFFFF_FFFF);
        drive(32'h0, 32'h0000_0002, 32'h0);
        check_reg("R2", "high bit 1 number", A_VEC, 32'd33);
        drive(32'h0, 32'h0000_0008, 32'h0);
        check_reg("R4", "invalid high bit 3", A_VEC, SPUR);
        check_irq("R4", 1'b0);
        drive(32'h0000_0008, 32'h0000_0400, 32'h0);
        check_reg("R3", "low beats high", A_VEC, 32'd3);
        wr(A_LOC, 32'h0);
        check_reg("R11", "write to low cause ignored", A_LOC, 32'h0000_0008);
        drive(32'h0, 32'h0000_0400, 32'h0);
        check_reg("R3", "high searched when low idle", A_VEC, 32'd42);
        drive(32'h0, 32'h0F00_0000, 32'h0);
        check_reg("R9", "summary bits not from high source", A_HIC, 32'h0);
        check_reg("R9", "no port pending", A_VEC, SPUR);
    endtask

    task automatic t_port_cascade;
        drive(32'h0, 32'h0, 32'h0);
        wr(A_HIM, 32'h0F00_0000);
        wr(A_PTM, 32'h0000_0084);
        drive(32'h0, 32'h0, 32'h0000_0080);
        check_reg("R9", "port bit 7 number", A_VEC, 32'd71);
        check_reg("R9", "summary field set", A_HIC, 32'h0F00_0000);
        check_irq("R10", 1'b1);
        drive(32'h0, 32'h0, 32'h0000_0084);
        check_reg("R5", "lowest port bit", A_VEC, 32'd66);
        wr(A_PTC, ~32'h0000_0004);
        check_reg("R8", "partial clear keeps others", A_PTC, 32'h0000_0080);
        check_reg("R7", "held pin does not re-set", A_VEC, 32'd71);
        // Edge and clear of bit 4 in the same cycle
        @(negedge clk);
        port_in = port_in | 32'h0000_0010;
        bus_addr = A_PTC; bus_wdata = ~32'h0000_0010; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check_reg("R8", "set wins over clear", A_PTC, 32'h0000_0090);
    endtask

    task automatic t_port_masking;
        wr(A_PTM, 32'h0);
        check_reg("R6", "port mask blocks summary", A_HIC, 32'h0);
        check_reg("R6", "port masked vector", A_VEC, SPUR);
        check_irq("R6", 1'b0);
        check_reg("R6", "port cause kept", A_PTC, 32'h0000_0090);
        wr(A_PTM, 32'h0000_0090);
        wr(A_HIM, 32'h0);
        check_reg("R9", "summary visible though masked", A_HIC, 32'h0F00_0000);
        check_reg("R6", "high mask blocks cascade", A_VEC, SPUR);
        wr(A_HIM, 32'h0F00_0000);
        check_reg("R9", "port bit 4 number", A_VEC, 32'd68);
        check_reg("R12", "vector read again", A_VEC, 32'd68);
        check_reg("R12", "vector read no side effect", A_PTC, 32'h0000_0090);
        wr(A_PTC, 32'h0);
        check_reg("R8", "clear all", A_PTC, 32'h0);
        check_reg("R8", "idle after clear", A_VEC, SPUR);
    endtask

    task automatic t_map;
        check_reg("R12", "unmapped read", A_NONE, 32'h0);
        wr(A_NONE, 32'hFFFF_FFFF);
        check_reg("R12", "unmapped write low mask", A_LOM, 32'hFFFF_FFFF);
        check_reg("R12", "unmapped write port mask", A_PTM, 32'h0000_0090);
        check_reg("R12", "unmapped still zero", A_NONE, 32'h0);
    endtask

    initial begin
        rst_n = 1'b0;
        lo_src = '0; hi_src = '0; port_in = '0;
        bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_low_group();
        t_filter_and_mask();
        t_high_group();
        t_port_cascade();
        t_port_masking();
        t_map();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule